// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives a single-data-rate SDRAM through its power-up procedure. The procedure has a fixed order. First it waits while the pins carry NOP. Then it closes every bank with one precharge and issues two auto-refresh commands. Last, it writes the mode register. After the final timing gap it raises a done flag, and the memory controller may then start normal traffic.

The block counts every interval in clock cycles. The power-up wait is derived from a clock-frequency parameter and a wait time in microseconds. The gaps after precharge, after each refresh and after the mode load are separate cycle-count parameters, and NOP is driven during each gap. The value written into the mode register is also a parameter. It goes out on the address bus with the bank address held low.

Command encodings in {cs_n, ras_n, cas_n, we_n} order are:

| Command | Encoding |
|---|---|
| INHIBIT | 1111 |
| NOP | 0111 |
| PRECHARGE | 0010 |
| AUTO REFRESH | 0001 |
| LOAD MODE | 0000 |

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While rst_n is low, the command is INHIBIT (1111), init_done is 0, and ba and addr are all zeros. This takes effect without waiting for a clock edge.
- R2: The wait phase begins at the first rising edge after rst_n goes high. From that edge the command is NOP (0111) for exactly CLK_MHZ*WAIT_US cycles, and no other command appears.
- R3: Right after the wait, PRECHARGE (0010) is driven for one cycle with addr = 12'h400 (only bit 10 set, meaning all banks) and ba = 0.
- R4: After the precharge, NOP is driven for exactly T_RP cycles before the first refresh.
- R5: Exactly two AUTO REFRESH (0001) commands are issued, each for one cycle with addr and ba zero. Each refresh is followed by exactly T_RFC NOP cycles. No refresh comes before the precharge.
- R6: After the second refresh gap, LOAD MODE (0000) is driven for one cycle with addr = MODE_VAL and ba = 0.
- R7: After the mode load, NOP is driven for exactly T_MRD cycles. init_done rises in the next cycle and stays high, with NOP on the command pins, until reset.
- R8: A reset at any point, including after init_done, restarts the whole sequence from R1 and R2. The full wait and every later step are repeated.
- R9: A gap parameter given as 0 is treated as 1, so every non-NOP command is followed by at least one NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, always 0 in this block |
| addr | output | 12 | Row/mode address; bit 10 selects all banks on precharge |
| init_done | output | 1 | High once initialization is complete |

## Verification
The hardest case to reach is a reset that lands partway through the sequence. It must send the block back to a full power-up wait, not resume where it stopped. Only a precisely timed reset in the middle of a gap shows this. The bench follows the expected cycle table until it is inside the first refresh gap and pulls reset there. After release it re-checks the full NOP wait and the exact cycle of the precharge. It then repeats the test with a reset after init_done, to show that the done flag falls and the whole sequence runs again.

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq #(
  parameter int          CLK_MHZ  = 100,
  parameter int          WAIT_US  = 100,
  parameter int          T_RP     = 2,
  parameter int          T_RFC    = 7,
  parameter int          T_MRD    = 2,
  parameter logic [11:0] MODE_VAL = 12'h033
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [11:0] addr,
  output logic        init_done
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int GRP = (T_RP  < 1) ? 1 : T_RP;
  localparam int GRF = (T_RFC < 1) ? 1 : T_RFC;
  localparam int GMR = (T_MRD < 1) ? 1 : T_MRD;
  localparam int M1 = (GRP > GRF) ? GRP : GRF;
  localparam int M2 = (M1 > GMR) ? M1 : GMR;
  localparam int CNT_MAX = (WAIT_CYC > M2) ? WAIT_CYC : M2;
  localparam int CW = $clog2(CNT_MAX + 1);

  typedef enum logic [3:0] {
    ST_RST, ST_WAIT, ST_PRE, ST_GRP, ST_REF1, ST_GRF1,
    ST_REF2, ST_GRF2, ST_MRS, ST_GMR, ST_DONE
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, lim;
  logic timed, last;
  logic [3:0] cmd;

  always_comb begin
    timed = 1'b1;
    case (st)
      ST_WAIT:          lim = CW'(WAIT_CYC);
      ST_GRP:           lim = CW'(GRP);
      ST_GRF1, ST_GRF2: lim = CW'(GRF);
      ST_GMR:           lim = CW'(GMR);
      default: begin
        lim   = CW'(1);
        timed = 1'b0;
      end
    endcase
  end

  assign last = (cnt == lim - CW'(1));

  always_comb begin
    case (st)
      ST_RST:  nxt = ST_WAIT;
      ST_WAIT: nxt = ST_PRE;
      ST_PRE:  nxt = ST_GRP;
      ST_GRP:  nxt = ST_REF1;
      ST_REF1: nxt = ST_GRF1;
      ST_GRF1: nxt = ST_REF2;
      ST_REF2: nxt = ST_GRF2;
      ST_GRF2: nxt = ST_MRS;
      ST_MRS:  nxt = ST_GMR;
      ST_GMR:  nxt = ST_DONE;
      default: nxt = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RST;
      cnt <= '0;
    end else if (timed && !last) begin
      cnt <= cnt + CW'(1);
    end else begin
      cnt <= '0;
      st  <= nxt;
    end
  end

  always_comb begin
    case (st)
      ST_RST:           cmd = 4'b1111;
      ST_PRE:           cmd = 4'b0010;
      ST_REF1, ST_REF2: cmd = 4'b0001;
      ST_MRS:           cmd = 4'b0000;
      default:          cmd = 4'b0111;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba        = 2'b00;
  assign addr      = (st == ST_PRE) ? 12'h400 : (st == ST_MRS) ? MODE_VAL : 12'h000;
  assign init_done = (st == ST_DONE);
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int          CLK_MHZ  = 100,
  parameter int          WAIT_US  = 100,
  parameter logic [11:0] MODE_VAL = 12'h033
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [11:0] addr,
  input logic        init_done
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  logic [3:0] c;
  assign c = {cs_n, ras_n, cas_n, we_n};

  logic pre_seen, mrs_seen;
  int   nop_cnt, ref_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_seen <= 1'b0;
      mrs_seen <= 1'b0;
      nop_cnt  <= 0;
      ref_cnt  <= 0;
    end else begin
      if (c == 4'b0010) pre_seen <= 1'b1;
      if (c == 4'b0000) mrs_seen <= 1'b1;
      if (c == 4'b0111 && !pre_seen && nop_cnt < WAIT_CYC) nop_cnt <= nop_cnt + 1;
      if (c == 4'b0001) ref_cnt <= ref_cnt + 1;
    end
  end

  // R2
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_seen && c != 4'b0010) |-> (c == 4'b0111 || c == 4'b1111));
  // R2
  wait_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0010) |-> (nop_cnt >= WAIT_CYC));
  // R3
  pre_all_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0010) |-> (addr == 12'h400 && ba == 2'b00));
  // R5
  ref_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0001) |-> (pre_seen && ref_cnt < 2));
  // R6
  mrs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |-> (ref_cnt == 2 && addr == MODE_VAL && ba == 2'b00));
  // R9
  gap_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c != 4'b0111 && c != 4'b1111) |=> (c == 4'b0111));
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R7
  done_after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (mrs_seen && c == 4'b0111));
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .MODE_VAL(MODE_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
);

// File: tb/sim_sdram_pwrup_seq.sv
module sim_sdram_pwrup_seq;
  localparam int          MHZ  = 250;
  localparam int          US   = 1;
  localparam int          W    = MHZ * US;
  localparam int          TRP  = 3;
  localparam int          TRFC = 5;
  localparam int          TMRD = 2;
  localparam logic [11:0] MV   = 12'h027;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001,
                         MRS = 4'b0000, INH = 4'b1111;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [11:0] addr;
    logic        done;
    logic [15:0] len;
  } seg_t;

  localparam int NSEG = 10;
  localparam seg_t SEG [0:NSEG-1] = '{
    '{NOP, 12'h000, 1'b0, 16'(W)},
    '{PRE, 12'h400, 1'b0, 16'd1},
    '{NOP, 12'h000, 1'b0, 16'(TRP)},
    '{REF, 12'h000, 1'b0, 16'd1},
    '{NOP, 12'h000, 1'b0, 16'(TRFC)},
    '{REF, 12'h000, 1'b0, 16'd1},
    '{NOP, 12'h000, 1'b0, 16'(TRFC)},
    '{MRS, MV,      1'b0, 16'd1},
    '{NOP, 12'h000, 1'b0, 16'(TMRD)},
    '{NOP, 12'h000, 1'b1, 16'd20}
  };
  localparam string TAG [0:NSEG-1] = '{"R2", "R3", "R4", "R5", "R5",
                                       "R5", "R5", "R6", "R7", "R7"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [11:0] addr;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdram_pwrup_seq #(.CLK_MHZ(MHZ), .WAIT_US(US), .T_RP(TRP), .T_RFC(TRFC),
                    .T_MRD(TMRD), .MODE_VAL(MV)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done));

  task automatic check(string tag, logic [3:0] ec, logic [11:0] ea, logic ed);
    logic [16:0] act, exp;
    act = {cs_n, ras_n, cas_n, we_n, addr, init_done} | {15'd0, 2'b00} ;
    exp = {ec, ea, ed};
    tests++;
    if (act !== exp || ba !== 2'b00) begin
      fails++;
      $display("FAIL %s: {cmd,addr,done,ba} actual %b_%h_%b_%b expected %b_%h_%b_00",
               tag, act[16:13], act[12:1], act[0], ba, ec, ea, ed);
    end
  endtask

  task automatic walk(int upto);
    for (int s = 0; s < upto; s++)
      for (int k = 0; k < int'(SEG[s].len); k++) begin
        @(negedge clk);
        check(TAG[s], SEG[s].cmd, SEG[s].addr, SEG[s].done);
      end
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(tag, INH, 12'h000, 1'b0);
    @(negedge clk);
    check(tag, INH, 12'h000, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1 check("R1", INH, 12'h000, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", INH, 12'h000, 1'b0);
    rst_n = 1'b1;
    walk(NSEG);
    // R8: reset inside the first refresh gap
    walk(0);
    do_reset("R8");
    walk(4);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R5", NOP, 12'h000, 1'b0);
    end
    do_reset("R8");
    walk(NSEG);
    // R8: reset after completion, then full rerun
    do_reset("R8");
    walk(NSEG);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule